// File: doc/BRIEF.md
# Temperature-Slope Output Code Calculator

This block computes, in fixed point, the voltage that a trimmable reference with a programmable temperature slope would present at its output. It takes an 8-bit reference code n, an 8-bit slope code m, a 2-bit gain field and a signed die temperature. It returns the result as a signed integer number of microvolts.

The output is Av × (1.2 V × n/255 + Vts × (2m − 255)/255), with Vts = −2.1 mV/°C × (T − 25 °C). The slope code is centred. Code 0 gives the full positive slope, code 255 gives the full negative slope, and the midpoint gives almost none. At 25 °C the temperature term is zero for every slope code.

A one-cycle start pulse captures all inputs. The result appears with a one-cycle valid pulse a fixed number of cycles later. A new start can be issued on every cycle. Division by 255 uses a constant reciprocal multiply followed by a one-step correction.

Top module: `tsref_calc`

## Requirements
- R1: The gain field decodes as 2'b00 to ×1, 2'b01 to ×2, 2'b10 to ×2 and 2'b11 to ×4, and the gain multiplies both the reference term and the temperature term.
- R2: With temperature t in units of 0.1 °C, let N = Av × (1200000 × n + 210 × (250 − t) × (2m − 255)). The output is floor((N + 127) / 255) microvolts, which is the nearest integer. No exact halves can occur because 255 is odd. Examples at Av = 1, n = 178, m = 74: 837647 at t = 250 and 890518 at t = 850.
- R3: At t = 250 the output equals round(Av × 1200000 × n / 255) for every slope code m.
- R4: With m = 255, Av = 1 and n = 255, the output is 1200000 at t = 250 and 1074000 at t = 850, which is a slope of −2.1 mV/°C.
- R5: out_valid is high for exactly one cycle, 5 clock edges after the edge that samples start high, counting that edge. out_valid never rises without a start.
- R6: The inputs are sampled only on the edge where start is high. Later changes to the inputs have no effect on that result.
- R7: out_uv holds its last value in every cycle where out_valid is low.
- R8: While reset is held, and in the first cycle after it is released, out_valid is 0 and out_uv is 0.
- R9: Back-to-back starts on consecutive cycles each produce their own correct result on consecutive cycles.
- R10: The result is exact across the full 16-bit signed temperature range (−32768 to 32767) for every code and gain, and it never overflows 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Captures the inputs and begins one computation |
| ref_code | input | 8 | Reference scale code n, 0 to 255 |
| slope_code | input | 8 | Centred slope code m, 0 to 255 |
| gain_sel | input | 2 | Output gain field |
| temp_deci | input | 16 | Signed die temperature, 0.1 °C per LSB |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_uv | output | 32 | Signed output voltage in microvolts |

## Verification
A wrong captured code, gain decode or product in any stage shows up in out_uv on the valid pulse five cycles after the start that fed it. Because each start is compared against its own expected value, an error cannot hide behind a neighbouring vector. An off-by-one in the reciprocal correction shows as a result that is one microvolt off for only some codes. The full sweep over n and m at ×4 is meant to expose it. A broken valid chain or hold register shows within one cycle: as a missing or extra strobe, or as out_uv moving while out_valid is low.

// File: rtl/tsref_pkg.sv
// Package: shared constants, derived widths and types for the
// temperature-slope output calculator. All widths below follow from the
// code width, temperature width and the physical constants.
package tsref_pkg;

    localparam int CODE_W    = 8;
    localparam int TEMP_W    = 16;
    localparam int OUT_W     = 32;
    localparam int LATENCY   = 5;

    localparam int CODE_MAX  = (1 << CODE_W) - 1;   // divisor, 255
    localparam int HALF_DIV  = CODE_MAX / 2;        // rounding offset, 127
    localparam int VREF_UV   = 1200000;             // reference, microvolts
    localparam int SLOPE_UV  = 210;                 // uV per 0.1 degC (negative sense)
    localparam int TREF_DECI = 250;                 // 25.0 degC

    localparam int REF_W  = $clog2(VREF_UV * CODE_MAX + 1);
    localparam int VTS_W  = TEMP_W + 2 + $clog2(SLOPE_UV + 1);
    localparam int SL_W   = CODE_W + 2;
    localparam int PROD_W = VTS_W + SL_W;
    localparam int SCL_W  = PROD_W + 3;             // sum carry plus x4 shift
    localparam int XW     = SCL_W + 1;              // biased dividend width
    localparam int QW     = XW - CODE_W + 1;        // quotient width

    localparam longint BIAS_Q = longint'(1) << (SCL_W - CODE_W);
    localparam longint BIAS_X = BIAS_Q * longint'(CODE_MAX);
    localparam longint RECIP  = (longint'(1) << XW) / longint'(CODE_MAX);

    typedef enum logic [1:0] {
        SH_X1 = 2'd0,
        SH_X2 = 2'd1,
        SH_X4 = 2'd2
    } gain_shift_e;

    typedef struct packed {
        logic [CODE_W-1:0] ref_code;
        logic [CODE_W-1:0] slope_code;
        logic [1:0]        gain;
        logic [TEMP_W-1:0] temp;
    } calc_req_t;

endpackage

// File: rtl/tsref_capture.sv
// Module: input capture stage. Latches a request on start and forwards a
// valid bit. Assumes start is a single-cycle pulse per computation; the
// held request is unchanged while start is low.
module tsref_capture
    import tsref_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  calc_req_t req_in,
    output calc_req_t req_q,
    output logic      req_vld
);

    // Capture the request only on start; strobe follows start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            req_vld <= 1'b0;
        end else begin
            req_vld <= start;
            if (start) begin
                req_q <= req_in;
            end
        end
    end

endmodule

// File: rtl/tsref_terms.sv
// Module: term stage. Forms the unscaled reference numerator (Vref*n), the
// signed temperature numerator Vts*(2m-255) and the gain shift amount.
// Assumes temperature in 0.1 degC two's complement; all terms exact.
module tsref_terms
    import tsref_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  calc_req_t                req,
    input  logic                     req_vld,
    output logic [REF_W-1:0]         ref_q,
    output logic signed [PROD_W-1:0] prod_q,
    output gain_shift_e              shift_q,
    output logic                     vld_q
);

    logic signed [TEMP_W:0]   tdiff;
    logic signed [VTS_W-1:0]  vts;
    logic signed [SL_W-1:0]   slope;
    logic signed [PROD_W-1:0] prod_d;
    logic [REF_W-1:0]         ref_d;
    gain_shift_e              shift_d;

    // Exact integer terms and gain decode from the captured request.
    always_comb begin
        tdiff  = $signed((TEMP_W+1)'(TREF_DECI)) - $signed({req.temp[TEMP_W-1], req.temp});
        vts    = $signed(VTS_W'(SLOPE_UV)) * VTS_W'(tdiff);
        slope  = $signed({1'b0, req.slope_code, 1'b0}) - $signed(SL_W'(CODE_MAX));
        prod_d = PROD_W'(vts) * PROD_W'(slope);
        ref_d  = REF_W'(VREF_UV) * REF_W'(req.ref_code);
        case (req.gain)
            2'b00:   shift_d = SH_X1;
            2'b01:   shift_d = SH_X2;
            2'b10:   shift_d = SH_X2;
            default: shift_d = SH_X4;
        endcase
    end

    // Register the terms for the summing stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            prod_q  <= '0;
            shift_q <= SH_X1;
            vld_q   <= 1'b0;
        end else begin
            ref_q   <= ref_d;
            prod_q  <= prod_d;
            shift_q <= shift_d;
            vld_q   <= req_vld;
        end
    end

    // R3: a request at 25.0 degC yields a zero temperature product.
    p_flat_at_tref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req.temp == TEMP_W'(TREF_DECI)) |=> (prod_q == '0));

endmodule

// File: rtl/tsref_scale.sv
// Module: sum and gain stage. Adds the two numerators, applies the gain
// shift, adds the rounding offset and a positive bias that makes the
// dividend unsigned. Assumes BIAS_X exceeds the largest negative sum.
module tsref_scale
    import tsref_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REF_W-1:0]         ref_q,
    input  logic signed [PROD_W-1:0] prod_q,
    input  gain_shift_e              shift_q,
    input  logic                     vld_in,
    output logic [XW-1:0]            x_q,
    output logic                     vld_q
);

    logic signed [SCL_W-1:0] sum_s;
    logic signed [SCL_W-1:0] scaled;
    logic [XW-1:0]           x_d;

    // Signed sum, gain shift, rounding offset and bias.
    always_comb begin
        sum_s  = $signed(SCL_W'(ref_q)) + SCL_W'(prod_q);
        scaled = sum_s <<< 2'(shift_q);
        x_d    = XW'(scaled) + XW'(HALF_DIV) + XW'(BIAS_X);
    end

    // Register the biased dividend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            vld_q <= 1'b0;
        end else begin
            x_q   <= x_d;
            vld_q <= vld_in;
        end
    end

endmodule

// File: rtl/tsref_div255.sv
// Module: two-stage floor division by 255 of an unsigned biased dividend.
// Stage A estimates the quotient with a truncated reciprocal (never above
// the true quotient, at most one below); stage B corrects by one, removes
// the bias and holds the result between valid strobes.
module tsref_div255
    import tsref_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XW-1:0]           x_in,
    input  logic                    vld_in,
    output logic signed [OUT_W-1:0] res,
    output logic                    res_vld
);

    logic [XW+QW-1:0] full;
    logic [QW-1:0]    q0_d;
    logic [QW-1:0]    q0;
    logic [XW-1:0]    x_d;
    logic             v_a;
    logic [XW:0]      rem;
    logic             corr;
    logic [QW-1:0]    qf;
    logic signed [QW:0] qs;

    // Reciprocal estimate of the quotient.
    always_comb begin
        full = (XW+QW)'(x_in) * (XW+QW)'(RECIP);
        q0_d = QW'(full >> XW);
    end

    // Stage A registers: estimate, dividend copy, valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0  <= '0;
            x_d <= '0;
            v_a <= 1'b0;
        end else begin
            q0  <= q0_d;
            x_d <= x_in;
            v_a <= vld_in;
        end
    end

    // Remainder check, one-step correction and bias removal.
    always_comb begin
        rem  = (XW+1)'(x_d) - (XW+1)'(q0) * (XW+1)'(CODE_MAX);
        corr = (rem >= (XW+1)'(CODE_MAX));
        qf   = q0 + QW'(corr);
        qs   = $signed({1'b0, qf}) - $signed((QW+1)'(BIAS_Q));
    end

    // Stage B: update result only on valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= v_a;
            if (v_a) begin
                res <= qs[OUT_W-1:0];
            end
        end
    end

    // R2: the reciprocal estimate is within one of the true quotient.
    p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_a |-> (rem < (XW+1)'(2 * CODE_MAX)));

    // R10: the unbiased quotient fits the output width.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        v_a |-> ((qs[QW:OUT_W-1] == '0) || (qs[QW:OUT_W-1] == '1)));

    // R7: without a valid entering stage B the result does not move.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !v_a |=> $stable(res));

endmodule

// File: rtl/tsref_calc.sv
// Module: top of the temperature-slope output calculator.
// out = Av*(Vref*n/255 + Vts*(2m-255)/255) in microvolts, rounded to the
// nearest microvolt, Vts = -2.1 mV/degC * (T - 25 degC). Five-edge
// latency from the edge sampling start; one new start per cycle allowed.
module tsref_calc
    import tsref_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CODE_W-1:0]        ref_code,
    input  logic [CODE_W-1:0]        slope_code,
    input  logic [1:0]               gain_sel,
    input  logic signed [TEMP_W-1:0] temp_deci,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_uv
);

    calc_req_t                req_in;
    calc_req_t                req_q;
    logic                     req_vld;
    logic [REF_W-1:0]         ref_t;
    logic signed [PROD_W-1:0] prod_t;
    gain_shift_e              shift_t;
    logic                     vld_t;
    logic [XW-1:0]            x_s;
    logic                     vld_s;
    logic [2:0]               since_rst;

    // Pack the port inputs into a request.
    always_comb begin
        req_in.ref_code   = ref_code;
        req_in.slope_code = slope_code;
        req_in.gain       = gain_sel;
        req_in.temp       = temp_deci;
    end

    tsref_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .req_in  (req_in),
        .req_q   (req_q),
        .req_vld (req_vld)
    );

    tsref_terms u_terms (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_q),
        .req_vld (req_vld),
        .ref_q   (ref_t),
        .prod_q  (prod_t),
        .shift_q (shift_t),
        .vld_q   (vld_t)
    );

    tsref_scale u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_q   (ref_t),
        .prod_q  (prod_t),
        .shift_q (shift_t),
        .vld_in  (vld_t),
        .x_q     (x_s),
        .vld_q   (vld_s)
    );

    tsref_div255 u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_in    (x_s),
        .vld_in  (vld_s),
        .res     (out_uv),
        .res_vld (out_valid)
    );

    // Cycles since reset release, saturating; guards the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R5: the valid strobe mirrors start exactly five edges later.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5) |-> (out_valid == $past(start, 5)));

endmodule

// File: tb/sim_tsref_calc.sv
`timescale 1ns/1ps
module sim_tsref_calc;

    localparam int LAT = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [7:0]         ref_code = '0;
    logic [7:0]         slope_code = '0;
    logic [1:0]         gain_sel = '0;
    logic signed [15:0] temp_deci = '0;
    logic               out_valid;
    logic signed [31:0] out_uv;

    int     n_vec = 0;
    int     n_bad = 0;
    string  tag = "R8";
    bit     checking = 1'b0;
    bit     done = 1'b0;
    logic   pv [LAT];
    longint pd [LAT];
    longint held = 0;

    always #2.5 clk = ~clk;

    tsref_calc u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ref_code   (ref_code),
        .slope_code (slope_code),
        .gain_sel   (gain_sel),
        .temp_deci  (temp_deci),
        .out_valid  (out_valid),
        .out_uv     (out_uv)
    );

    // Arithmetic model from R1/R2: floor((N+127)/255), floor for negatives.
    function automatic longint model(input int n, input int m, input int g, input int t);
        longint av, vts, num, x;
        av  = (g == 0) ? 1 : ((g == 3) ? 4 : 2);
        vts = 210 * (250 - longint'(t));
        num = av * (1200000 * longint'(n) + vts * longint'(2 * m - 255));
        x   = num + 127;
        if (x >= 0) return x / 255;
        return -((-x + 254) / 255);
    endfunction

    // Expected-result pipeline, LAT entries deep, indexed by edges since start.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pv[i] <= 1'b0;
                pd[i] <= 0;
            end
        end else begin
            pv[0] <= start;
            pd[0] <= model(int'(ref_code), int'(slope_code), int'(gain_sel), int'(temp_deci));
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pd[i] <= pd[i-1];
            end
        end
    end

    // Every-cycle check of strobe and value (R5, R7 and the current phase tag).
    always @(negedge clk) begin
        if (checking && !done) begin
            if (pv[LAT-1]) held = pd[LAT-1];
            n_vec++;
            if (out_valid !== pv[LAT-1] || longint'(out_uv) != held) begin
                n_bad++;
                $display("FAIL %s valid=%0b value=%0d expected valid=%0b value=%0d",
                         tag, out_valid, out_uv, pv[LAT-1], held);
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic put(input int n, input int m, input int g, input int t);
        @(negedge clk);
        ref_code   = 8'(n);
        slope_code = 8'(m);
        gain_sel   = 2'(g);
        temp_deci  = 16'(t);
        start      = 1'b1;
    endtask

    // Idle cycles with moving inputs and no start.
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start      = 1'b0;
            ref_code   = ref_code + 8'd37;
            slope_code = slope_code + 8'd91;
            gain_sel   = gain_sel + 2'd1;
            temp_deci  = temp_deci + 16'sd1111;
        end
    endtask

    // One isolated computation with literal expectation and latency check.
    task automatic single(input int n, input int m, input int g, input int t,
                          input longint expv, input string rq, input bit scramble);
        int seen;
        int hits;
        seen = 0;
        hits = 0;
        tag = rq;
        put(n, m, g, t);
        for (int i = 1; i <= LAT + 3; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (scramble) begin
                ref_code   = ~ref_code;
                slope_code = slope_code + 8'd13;
                gain_sel   = ~gain_sel;
                temp_deci  = temp_deci - 16'sd777;
            end
            if (out_valid) begin
                hits++;
                if (seen == 0) seen = i;
            end
        end
        n_vec++;
        if (seen != LAT || hits != 1) begin
            n_bad++;
            $display("FAIL R5 latency=%0d pulses=%0d expected latency=%0d pulses=1", seen, hits, LAT);
        end
        n_vec++;
        if (longint'(out_uv) != expv) begin
            n_bad++;
            $display("FAIL %s value=%0d expected=%0d", rq, out_uv, expv);
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        // R8: reset state, during and just after reset.
        repeat (4) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_uv !== 32'sd0) begin
            n_bad++;
            $display("FAIL R8 in reset valid=%0b value=%0d expected valid=0 value=0", out_valid, out_uv);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_uv !== 32'sd0) begin
            n_bad++;
            $display("FAIL R8 after reset valid=%0b value=%0d expected valid=0 value=0", out_valid, out_uv);
        end
        checking = 1'b1;

        // R2 worked values, R4 slope, R1 gains, R6 sampling on start.
        single(178, 74, 0, 250, 837647, "R2", 1'b0);
        single(178, 74, 0, 850, 890518, "R2", 1'b0);
        single(255, 255, 0, 250, 1200000, "R4", 1'b0);
        single(255, 255, 0, 850, 1074000, "R4", 1'b0);
        single(255, 255, 1, 850, 2148000, "R1", 1'b0);
        single(255, 255, 2, 850, 2148000, "R1", 1'b0);
        single(255, 128, 3, 250, 4800000, "R1", 1'b0);
        single(178, 74, 0, 850, 890518, "R6", 1'b1);

        // R5 / R7: no start, moving inputs, no strobe, held value.
        tag = "R5";
        idle(20);
        tag = "R7";
        idle(20);

        // R9 (and R2): every n and m back to back at x4, -40.0 degC.
        tag = "R9";
        for (int n = 0; n < 256; n++)
            for (int m = 0; m < 256; m++)
                put(n, m, 3, -400);
        idle(LAT + 2);

        // R3: at 25.0 degC the slope code has no effect.
        tag = "R3";
        for (int g = 0; g < 4; g++)
            for (int n = 0; n < 256; n++)
                for (int k = 0; k < 6; k++)
                    put(n, (k < 3) ? k * 64 : 255 - (k - 3) * 63, g, 250);
        idle(LAT + 2);

        // R1: all gains at 85.0 degC.
        tag = "R1";
        for (int g = 0; g < 4; g++)
            for (int n = 0; n < 256; n++)
                for (int m = 0; m < 256; m += 17)
                    put(n, m, g, 850);
        idle(LAT + 2);

        // R10: temperature extremes with all slope codes and gains.
        tag = "R10";
        for (int k = 0; k < 4; k++)
            for (int g = 0; g < 4; g++)
                for (int j = 0; j < 3; j++)
                    for (int m = 0; m < 256; m++)
                        put((j == 0) ? 0 : ((j == 1) ? 255 : 128), m, g,
                            (k == 0) ? -32768 : ((k == 1) ? 32767 : ((k == 2) ? -32767 : 0)));
        idle(LAT + 2);

        // R2: odd temperature, mixed codes at x1.
        tag = "R2";
        for (int n = 0; n < 256; n += 3)
            for (int m = 0; m < 256; m += 5)
                put(n, m, 0, 1234);
        idle(LAT + 2);

        report();
    end

endmodule